// File: doc/BRIEF.md
# Burst ROM Read Bus Controller

This block sequences the external bus cycles for a ROM that supports page-mode or burst-mode reads. A requester hands it one transfer at a time: a start address, an access size (1, 2 or 4 bytes, or a 16, 32 or 64 byte line) and a direction. The block splits that transfer into bus beats of the configured bus width, and groups the beats into accesses. It drives the ROM address, chip select, read strobe, write strobe and bus-start strobe. It samples the ROM data bus and an external wait input, and returns each read word with a one-cycle valid pulse.

Within one access the strobes stay asserted and only the address steps from beat to beat. The opening beat of an access waits for a long configurable count and can be stretched further by the external wait input. Every later beat waits for a short count of its own and ignores the external wait input. Line reads are grouped into accesses according to the bus width and a two-bit burst mode. On a 16-bit bus, one mode picks the grouping from the start address. Sub-line reads and all writes use plain one-beat accesses.

Top module: `burst_rom_rd_ctrl`

## Requirements
- R1: A transfer has max(1, size/width) beats. The beat addresses start at req_addr rounded down to a multiple of the bus width and rise by the width in bytes. Each read beat produces one rd_valid pulse, in the cycle after the beat's last cycle, carrying the rom_data value sampled in that last cycle. Size codes: 0=1 byte, 1=2, 2=4, 3=16, 4=32, 5=64. Width codes: 0=8 bits, 1=16 bits, 2=32 bits.
- R2: Line reads (size code 3 to 5) use these access lengths. On an 8-bit bus: 4 beats in mode 1, 16 beats otherwise. On a 16-bit bus: 8 beats in modes 0 and 3, 2 beats in mode 1. On a 32-bit bus: 4 beats in every mode.
- R3: For a line read on a 16-bit bus in mode 2, start-address bit 2 selects the grouping. When the bit is 0, each 16-byte chunk is fetched as two 4-beat accesses. When the bit is 1, each chunk is fetched as accesses of 2, 4 and 2 beats.
- R4: Within one access, rom_cs_n and the active strobe stay low from the first beat to the last, and only rom_addr changes between beats.
- R5: rom_bs_n is low exactly during the first beat of each access. That beat lasts cfg_first_wait+1 cycles. If rom_wait is high once the count has run out, the beat is extended until rom_wait is low.
- R6: Every later beat of an access lasts exactly cfg_next_wait+1 cycles, whatever the level of rom_wait.
- R7: Between two accesses of one transfer, rom_cs_n and the strobes are high for exactly one cycle. busy is therefore high for the sum of the beat lengths plus one cycle per access boundary.
- R8: Reads of 1, 2 or 4 bytes send each beat as an access of its own.
- R9: A write drives rom_we_n instead of rom_rd_n and produces no rd_valid. It uses one-beat accesses, and a size code above 2 is treated as 4 bytes. rom_wdata presents req_wdata least-significant lane first, shifted down by one bus width per beat.
- R10: While reset is asserted and after its release, busy and rd_valid are low and rom_cs_n, rom_rd_n, rom_we_n and rom_bs_n are high.
- R11: A request is taken only while busy is low. busy goes high the cycle after acceptance. A req_valid pulse while busy starts no further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_write | input | 1 | 1 = write transfer |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | 3 | Size code (R1) |
| req_wdata | input | DATA_W | Write data, lane 0 first |
| cfg_bus_width | input | 2 | Bus width code (R1) |
| cfg_burst_mode | input | 2 | Burst grouping mode (R2, R3) |
| cfg_first_wait | input | FW_W | Wait cycles of the first beat |
| cfg_next_wait | input | NW_W | Wait cycles of each later beat |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | One pulse per read beat |
| rd_data | output | DATA_W | Read word of the beat |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_cs_n | output | 1 | Chip select, active low |
| rom_rd_n | output | 1 | Read strobe, active low |
| rom_we_n | output | 1 | Write strobe, active low |
| rom_bs_n | output | 1 | Bus-start strobe, active low |
| rom_wdata | output | DATA_W | Write data bus |
| rom_data | input | DATA_W | ROM read data |
| rom_wait | input | 1 | External wait request |

## Verification
Directed transfers cover each bus width and burst mode. Their access counts separate the fixed groupings from the address-dependent 4-4 and 2-4-2 splits, which are tried at all four word offsets. The bench's ROM returns a word derived from its address, so the returned data show whether the address sequence is right. rom_wait is held high through every later beat and for a chosen number of cycles in each first beat: the measured strobe and bus-start lengths show whether the first-beat stall is honoured and the later-beat one ignored. Random transfers mix sizes, widths, modes, wait counts and directions. A mid-transfer request tests that busy blocks new requests.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_NEXT  = 2'd2,
    ST_GAP   = 2'd3
  } brc_state_e;

  // log2 of the transfer size in bytes for a size code
  function automatic logic [2:0] size_log2(input logic [2:0] code);
    case (code)
      3'd0:    size_log2 = 3'd0;
      3'd1:    size_log2 = 3'd1;
      3'd2:    size_log2 = 3'd2;
      3'd3:    size_log2 = 3'd4;
      3'd4:    size_log2 = 3'd5;
      3'd5:    size_log2 = 3'd6;
      default: size_log2 = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/brc_plan.sv
module brc_plan #(
  parameter int IDX_W = 6
) (
  input  logic [2:0]       size_code,
  input  logic [1:0]       width_code,
  input  logic [1:0]       mode,
  input  logic             is_write,
  input  logic             start_bit2,
  output logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] grp_mask,
  output logic             split,
  output logic [1:0]       wlog
);
  import brc_pkg::*;

  logic [2:0]     slog;
  logic [2:0]     blog;
  logic [2:0]     glog;
  logic           line;
  logic [IDX_W:0] beats_sh;
  logic [IDX_W:0] grp_sh;

  always_comb begin
    case (width_code)
      2'd0:    wlog = 2'd0;
      2'd1:    wlog = 2'd1;
      default: wlog = 2'd2;
    endcase
    slog = size_log2(size_code);
    if (is_write && slog > 3'd2) slog = 3'd2;
    blog = (slog > {1'b0, wlog}) ? slog - {1'b0, wlog} : 3'd0;
    line = (slog >= 3'd4) && !is_write;
    glog  = 3'd0;
    split = 1'b0;
    if (line) begin
      case (wlog)
        2'd0: glog = (mode == 2'd1) ? 3'd2 : 3'd4;
        2'd1: begin
          case (mode)
            2'd1:    glog = 3'd1;
            2'd2:    begin glog = 3'd2; split = start_bit2; end
            default: glog = 3'd3;
          endcase
        end
        default: glog = 3'd2;
      endcase
    end
    beats_sh = (IDX_W+1)'(1) << blog;
    grp_sh   = (IDX_W+1)'(1) << glog;
    last_idx = IDX_W'(beats_sh - (IDX_W+1)'(1));
    grp_mask = IDX_W'(grp_sh - (IDX_W+1)'(1));
  end

endmodule

// File: rtl/brc_wait_cnt.sv
module brc_wait_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/burst_rom_rd_ctrl.sv
module burst_rom_rd_ctrl #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int FW_W   = 4,
  parameter int NW_W   = 2,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        cfg_bus_width,
  input  logic [1:0]        cfg_burst_mode,
  input  logic [FW_W-1:0]   cfg_first_wait,
  input  logic [NW_W-1:0]   cfg_next_wait,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_cs_n,
  output logic              rom_rd_n,
  output logic              rom_we_n,
  output logic              rom_bs_n,
  output logic [DATA_W-1:0] rom_wdata,
  input  logic [DATA_W-1:0] rom_data,
  input  logic              rom_wait
);
  import brc_pkg::*;

  brc_state_e        state_q, state_d;
  logic [IDX_W-1:0]  last_q, gmask_q, idx_q;
  logic              split_q, wr_q;
  logic [1:0]        wlog_q;
  logic [FW_W-1:0]   fw_q;
  logic [NW_W-1:0]   nw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wbuf_q, wbuf_shift;
  logic              rdv_q;
  logic [DATA_W-1:0] rdata_q;

  logic [IDX_W-1:0]  p_last, p_mask;
  logic              p_split;
  logic [1:0]        p_wlog;
  logic [ADDR_W-1:0] start_addr;

  logic              accept, in_beat, beat_done, is_last, grp_end;
  logic              w_load, w_zero, w_dec;
  logic [FW_W-1:0]   w_val;

  brc_plan #(.IDX_W(IDX_W)) u_plan (
    .size_code  (req_size),
    .width_code (cfg_bus_width),
    .mode       (cfg_burst_mode),
    .is_write   (req_write),
    .start_bit2 (req_addr[2]),
    .last_idx   (p_last),
    .grp_mask   (p_mask),
    .split      (p_split),
    .wlog       (p_wlog)
  );

  brc_wait_cnt #(.W(FW_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (w_load),
    .load_val (w_val),
    .dec      (w_dec),
    .zero     (w_zero)
  );

  assign start_addr = req_addr & ~((ADDR_W'(1) << p_wlog) - ADDR_W'(1));
  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign in_beat    = (state_q == ST_FIRST) || (state_q == ST_NEXT);
  assign beat_done  = ((state_q == ST_FIRST) && w_zero && !rom_wait) ||
                      ((state_q == ST_NEXT) && w_zero);
  assign is_last    = (idx_q == last_q);
  // 2-4-2 split ends groups at chunk beats 1, 5 and 7
  assign grp_end    = is_last ||
                      (split_q ? (idx_q[0] && (idx_q[2:0] != 3'd3))
                               : ((idx_q & gmask_q) == gmask_q));
  assign w_dec      = in_beat && !w_zero && !w_load;

  always_comb begin
    state_d = state_q;
    w_load  = 1'b0;
    w_val   = fw_q;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        state_d = ST_FIRST;
        w_load  = 1'b1;
        w_val   = cfg_first_wait;
      end
      ST_FIRST, ST_NEXT: if (beat_done) begin
        if (is_last)      state_d = ST_IDLE;
        else if (grp_end) state_d = ST_GAP;
        else begin
          state_d = ST_NEXT;
          w_load  = 1'b1;
          w_val   = FW_W'(nw_q);
        end
      end
      default: begin
        state_d = ST_FIRST;
        w_load  = 1'b1;
        w_val   = fw_q;
      end
    endcase
  end

  always_comb begin
    case (wlog_q)
      2'd0:    wbuf_shift = wbuf_q >> 8;
      2'd1:    wbuf_shift = wbuf_q >> 16;
      default: wbuf_shift = wbuf_q >> 32;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      gmask_q <= '0;
      split_q <= 1'b0;
      wlog_q  <= '0;
      wr_q    <= 1'b0;
      fw_q    <= '0;
      nw_q    <= '0;
    end else if (accept) begin
      last_q  <= p_last;
      gmask_q <= p_mask;
      split_q <= p_split;
      wlog_q  <= p_wlog;
      wr_q    <= req_write;
      fw_q    <= cfg_first_wait;
      nw_q    <= cfg_next_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      idx_q  <= '0;
      wbuf_q <= '0;
    end else if (accept) begin
      addr_q <= start_addr;
      idx_q  <= '0;
      wbuf_q <= req_wdata;
    end else if (beat_done) begin
      addr_q <= is_last ? addr_q : addr_q + (ADDR_W'(1) << wlog_q);
      idx_q  <= idx_q + IDX_W'(1);
      wbuf_q <= wbuf_shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdv_q <= 1'b0;
    else        rdv_q <= beat_done && !wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rdata_q <= '0;
    else if (beat_done && !wr_q)   rdata_q <= rom_data;
  end

  assign busy      = (state_q != ST_IDLE);
  assign rd_valid  = rdv_q;
  assign rd_data   = rdata_q;
  assign rom_addr  = addr_q;
  assign rom_cs_n  = !in_beat;
  assign rom_rd_n  = !(in_beat && !wr_q);
  assign rom_we_n  = !(in_beat && wr_q);
  assign rom_bs_n  = !(state_q == ST_FIRST);
  assign rom_wdata = wbuf_q;

endmodule

// File: rtl/burst_rom_rd_ctrl_chk.sv
module burst_rom_rd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic rd_valid,
  input logic rom_cs_n,
  input logic rom_rd_n,
  input logic rom_we_n,
  input logic rom_bs_n
);

  a_r5_bs_inside_access: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_bs_n |-> !rom_cs_n);

  a_r5_access_opens_with_bs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_cs_n) |-> !rom_bs_n);

  a_r6_bs_not_again_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n && $past(!rom_cs_n) && $past(rom_bs_n)) |-> rom_bs_n);

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs_n |-> (rom_rd_n != rom_we_n));

  a_r4_no_strobe_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs_n |-> (rom_rd_n && rom_we_n));

  a_r1_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!rom_rd_n));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rom_cs_n && rom_bs_n));

  a_r7_single_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rom_cs_n) && busy) |=> !rom_cs_n);

endmodule

bind burst_rom_rd_ctrl burst_rom_rd_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .rd_valid (rd_valid),
  .rom_cs_n (rom_cs_n),
  .rom_rd_n (rom_rd_n),
  .rom_we_n (rom_we_n),
  .rom_bs_n (rom_bs_n)
);

// File: tb/burst_rom_rd_ctrl_test.sv
`timescale 1ns/1ps
module burst_rom_rd_ctrl_test;

  localparam int AW = 24;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [2:0]    req_size;
  logic [DW-1:0] req_wdata;
  logic [1:0]    cfg_bus_width, cfg_burst_mode;
  logic [3:0]    cfg_first_wait;
  logic [1:0]    cfg_next_wait;
  logic          busy, rd_valid;
  logic [DW-1:0] rd_data, rom_wdata, rom_data;
  logic [AW-1:0] rom_addr;
  logic          rom_cs_n, rom_rd_n, rom_we_n, rom_bs_n, rom_wait;

  int checks = 0;
  int errors = 0;
  int stall_k = 0;
  int bs_run = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] romf(input logic [AW-1:0] a);
    return {a[15:0] ^ 16'h5AC3, a[7:0] ^ 8'h3C, a[7:0]};
  endfunction

  assign rom_data = romf(rom_addr);
  assign rom_wait = rom_bs_n ? 1'b1 : (bs_run < stall_k);

  always @(posedge clk) begin
    if (!rom_bs_n) bs_run <= bs_run + 1;
    else           bs_run <= 0;
  end

  burst_rom_rd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .cfg_bus_width(cfg_bus_width), .cfg_burst_mode(cfg_burst_mode),
    .cfg_first_wait(cfg_first_wait), .cfg_next_wait(cfg_next_wait),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .rom_addr(rom_addr),
    .rom_cs_n(rom_cs_n), .rom_rd_n(rom_rd_n), .rom_we_n(rom_we_n),
    .rom_bs_n(rom_bs_n), .rom_wdata(rom_wdata), .rom_data(rom_data),
    .rom_wait(rom_wait)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int slog_of(input int code);
    case (code)
      0: return 0; 1: return 1; 2: return 2;
      3: return 4; 4: return 5; default: return 6;
    endcase
  endfunction

  // expected number of accesses from R2, R3, R8, R9
  function automatic int exp_groups(input bit wr, input int sl, input int wl,
                                    input int mode, input int beats, input bit b2);
    if (wr || sl < 4) return beats;
    if (wl == 0) return (mode == 1) ? beats / 4 : beats / 16;
    if (wl == 1) begin
      if (mode == 1) return beats / 2;
      if (mode == 2) return b2 ? (beats / 8) * 3 : beats / 4;
      return beats / 8;
    end
    return beats / 4;
  endfunction

  task automatic run(input bit wr, input logic [AW-1:0] addr, input int size,
                     input int width, input int mode, input int fw, input int nw,
                     input int k, input logic [DW-1:0] wdata, input string tag,
                     input bit poke);
    int sl, wl, wb, beats, groups, first_len, n, acc, bs_c, st_c, busy_c;
    longint mask;
    logic [AW-1:0] base;
    bit prev_cs;
    sl = slog_of(size);
    if (wr && sl > 2) sl = 2;
    wl = (width == 0) ? 0 : (width == 1) ? 1 : 2;
    wb = 1 << wl;
    beats = (sl > wl) ? (1 << (sl - wl)) : 1;
    groups = exp_groups(wr, sl, wl, mode, beats, addr[2]);
    first_len = ((fw > k) ? fw : k) + 1;
    mask = (wl == 2) ? 64'hFFFF_FFFF : (wl == 1) ? 64'hFFFF : 64'hFF;
    base = addr & ~AW'(wb - 1);
    @(negedge clk);
    cfg_bus_width = 2'(width); cfg_burst_mode = 2'(mode);
    cfg_first_wait = 4'(fw); cfg_next_wait = 2'(nw); stall_k = k;
    req_write = wr; req_addr = addr; req_size = 3'(size); req_wdata = wdata;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", busy, 1);
    n = 0; acc = 0; bs_c = 0; st_c = 0; busy_c = 0; prev_cs = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (poke && cyc == 2) begin req_valid = 1'b1; req_addr = addr ^ 24'h000400; end
      if (poke && cyc == 3) req_valid = 1'b0;
      if (busy) busy_c++;
      if (!rom_bs_n) bs_c++;
      if (wr ? !rom_we_n : !rom_rd_n) st_c++;
      if (wr && !rom_rd_n) chk(0, "R9 read strobe on write", 0, 1);
      if (!rom_cs_n && prev_cs) begin
        if (wr) chk(((longint'(rom_wdata) ^ (longint'(wdata) >> (acc * 8 * wb))) & mask) == 0,
                    "R9 write lane", rom_wdata & mask, (longint'(wdata) >> (acc * 8 * wb)) & mask);
        acc++;
      end
      prev_cs = rom_cs_n;
      if (rd_valid) begin
        logic [DW-1:0] e;
        e = romf(base + AW'(n * wb));
        chk(rd_data == e, "R1 read word", rd_data, e);
        n++;
      end
      if (!busy) break;
      @(negedge clk);
    end
    chk(n == (wr ? 0 : beats), "R1 beat count", n, wr ? 0 : beats);
    chk(acc == groups, tag, acc, groups);
    chk(bs_c == groups * first_len, "R5 bus-start cycles", bs_c, groups * first_len);
    chk(st_c == groups * first_len + (beats - groups) * (nw + 1),
        "R6 strobe cycles", st_c, groups * first_len + (beats - groups) * (nw + 1));
    chk(busy_c == st_c + groups - 1, "R7 busy cycles", busy_c, st_c + groups - 1);
    if (poke) begin
      int extra = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (busy || rd_valid || !rom_cs_n) extra++;
      end
      chk(extra == 0, "R11 request while busy ignored", extra, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int dummy;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = '0; req_wdata = '0; cfg_bus_width = '0; cfg_burst_mode = '0;
    cfg_first_wait = '0; cfg_next_wait = '0;
    repeat (3) @(negedge clk);
    chk({busy, rd_valid, rom_cs_n, rom_rd_n, rom_we_n, rom_bs_n} == 6'b001111,
        "R10 reset outputs", {busy, rd_valid, rom_cs_n, rom_rd_n, rom_we_n, rom_bs_n}, 6'b001111);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, rd_valid, rom_cs_n, rom_bs_n} == 4'b0011, "R10 idle after reset",
        {busy, rd_valid, rom_cs_n, rom_bs_n}, 4'b0011);

    // R2 fixed groupings
    run(0, 24'h001000, 3, 0, 0, 2, 1, 0, 0, "R2 8-bit mode0 accesses", 0);
    run(0, 24'h001000, 3, 0, 1, 1, 0, 0, 0, "R2 8-bit mode1 accesses", 0);
    run(0, 24'h002001, 4, 1, 0, 0, 2, 0, 0, "R2 16-bit mode0 accesses", 0);
    run(0, 24'h002000, 3, 1, 1, 3, 3, 0, 0, "R2 16-bit mode1 accesses", 0);
    run(0, 24'h003000, 5, 2, 1, 1, 1, 0, 0, "R2 32-bit accesses", 0);
    // R3 address-dependent split
    run(0, 24'h004000, 3, 1, 2, 1, 1, 0, 0, "R3 offset 0 gives 4-4", 0);
    run(0, 24'h004004, 3, 1, 2, 1, 1, 0, 0, "R3 offset 4 gives 2-4-2", 0);
    run(0, 24'h004008, 4, 1, 2, 0, 0, 0, 0, "R3 offset 8 gives 4-4", 0);
    run(0, 24'h00400C, 4, 1, 2, 2, 1, 0, 0, "R3 offset C gives 2-4-2", 0);
    // R5 stall honoured in first beat, R6 ignored later
    run(0, 24'h005000, 3, 2, 0, 1, 2, 5, 0, "R5 stalled accesses", 0);
    run(0, 24'h005010, 3, 1, 0, 6, 0, 3, 0, "R5 stall below count", 0);
    // R8 sub-line reads
    run(0, 24'h006003, 2, 0, 0, 1, 3, 0, 0, "R8 4-byte on 8-bit", 0);
    run(0, 24'h006003, 1, 1, 1, 0, 0, 2, 0, "R8 2-byte on 16-bit", 0);
    // R9 writes
    run(1, 24'h007000, 2, 0, 0, 1, 1, 0, 32'hA1B2C3D4, "R9 write 4 bytes 8-bit", 0);
    run(1, 24'h007002, 5, 1, 1, 0, 0, 1, 32'h12345678, "R9 line write clamped", 0);
    // R11 request while busy
    run(0, 24'h008000, 3, 0, 0, 1, 1, 0, 0, "R11 access count", 1);

    dummy = $urandom(32'h00C0FFEE);
    for (int t = 0; t < 60; t++) begin
      bit wr;
      int sz, wd;
      wr = ($urandom % 8) == 0;
      sz = $urandom % 6;
      wd = $urandom % 3;
      run(wr, AW'($urandom), sz, wd, $urandom % 4, $urandom % 16, $urandom % 4,
          $urandom % 7, $urandom, wr ? "R9 random accesses" : "R2 random accesses", 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule